// File: doc/BRIEF.md
# Page Translation Cache with Table Walk

This block turns virtual addresses into physical addresses. A small, fully associative translation cache sits in front of a single-level page table. The table is kept in a local memory array that is indexed by virtual page number. Each request carries a virtual address and a write flag, and the block answers with a physical address, a fault indication and the page's modified state. On a hit in the cache the answer comes in the next cycle. On a miss the block reads the table entry, and if the page is resident it loads that entry into the cache and answers. If the page is not resident it reports a fault and produces no address.

The physical address is the frame number placed above the untouched page offset. Every cached entry stores its full virtual page number, and all entries are compared at once. The block keeps a dirty flag for each page in both places: the first write to a page sets it in the cache entry and in the table entry. A flush input drops every cached translation at once.

The page table is loaded through a dedicated install port, one entry per cycle. The surrounding system uses that port to make pages present or absent and to choose their frames.

Top module: `xlat_tlb`

## Requirements
- R1: A request accepted while its page is cached produces `rsp_valid` in the next cycle, with `rsp_fault` low and `rsp_paddr` equal to {cached frame, address bits [OFFSET_W-1:0]}.
- R2: A request accepted while its page is not cached produces `rsp_valid` exactly three cycles after acceptance. The address is built from the frame held in the page table entry.
- R3: A miss on a page table entry whose present bit is 0 responds with `rsp_fault` high, `rsp_paddr` zero and `rsp_modified` low. It does not load the cache, so a repeat of the same page misses again.
- R4: A miss on a present page loads the lowest-numbered empty cache slot. When no slot is empty it loads the slot named by a rotating pointer, and the pointer then advances by one and wraps after the last slot. A flush does not move the pointer.
- R5: A write translation reports `rsp_modified` = 1. The first write to a page also sets the modified bit of its page table entry.
- R6: A read translation leaves the modified state unchanged and reports the stored value.
- R7: A one-cycle `flush` empties the cache, so every following request misses until entries are loaded again.
- R8: `req_ready` is low from the cycle after a miss is accepted until its response. Requests presented while `req_ready` is low are ignored.
- R9: After reset `req_ready` is high, `rsp_valid` is low and the cache is empty.
- R10: After a successful translation the cache holds the entry for that page, so an immediate repeat hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all cached translations |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | VADDR_W | Virtual address |
| req_write | input | 1 | Request is a write |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_paddr | output | PADDR_W | Physical address |
| rsp_fault | output | 1 | Page not present |
| rsp_modified | output | 1 | Modified state of the page after this access |
| pte_wr_en | input | 1 | Install a page table entry |
| pte_wr_vpn | input | VADDR_W-OFFSET_W | Page number to install |
| pte_wr_present | input | 1 | Present bit to install |
| pte_wr_modified | input | 1 | Modified bit to install |
| pte_wr_frame | input | PADDR_W-OFFSET_W | Frame number to install |

## Verification
The assertions assume that `flush` is never raised in the same cycle as a table walk's final step. They also assume that installs through the table port never touch a page while that page is being walked or marked. Under these assumptions the cache never holds two copies of one page, and its dirty flags agree with the table. The stimulus installs table entries only while no request is in flight. It raises `flush` only while the block is idle, and it flushes after rewriting entries, so no cached copy goes stale. Stray requests are driven only during a walk, which checks that they are ignored.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

   typedef enum logic [1:0] {
      WALK_IDLE  = 2'd0,
      WALK_FETCH = 2'd1,
      WALK_CHECK = 2'd2
   } walk_state_e;

   function automatic int idx_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/xlat_tlb_cam.sv
module xlat_tlb_cam #(
   parameter int ENTRIES = 4,
   parameter int VPN_W   = 8,
   parameter int PFN_W   = 6,
   parameter int IDX_W   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [VPN_W-1:0] lookup_vpn,
   output logic             hit,
   output logic [IDX_W-1:0] hit_idx,
   output logic [PFN_W-1:0] hit_pfn,
   output logic             hit_mod,
   input  logic             fill_en,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [PFN_W-1:0] fill_pfn,
   input  logic             fill_mod,
   input  logic             setmod_en,
   input  logic [IDX_W-1:0] setmod_idx
);

   if (ENTRIES < 1) begin : g_bad_entries
      $error("xlat_tlb_cam: ENTRIES must be at least 1");
   end
   if ((1 << IDX_W) < ENTRIES) begin : g_bad_idx
      $error("xlat_tlb_cam: IDX_W too narrow for ENTRIES");
   end

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

   logic [ENTRIES-1:0] ent_valid;
   logic [ENTRIES-1:0] ent_mod;
   logic [ENTRIES-1:0] match;
   logic [VPN_W-1:0]   ent_vpn [ENTRIES];
   logic [PFN_W-1:0]   ent_pfn [ENTRIES];

   logic [IDX_W-1:0] rr_q;
   logic [IDX_W-1:0] free_idx;
   logic [IDX_W-1:0] victim;
   logic             any_free;
   logic             do_fill;

   assign do_fill = fill_en && !flush;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      logic             valid_q;
      logic             mod_q;
      logic [VPN_W-1:0] vpn_q;
      logic [PFN_W-1:0] pfn_q;
      logic             we;
      logic             mark;

      assign we   = do_fill && (victim == IDX_W'(g));
      assign mark = setmod_en && !flush && (setmod_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_q <= 1'b0;
            mod_q   <= 1'b0;
            vpn_q   <= '0;
            pfn_q   <= '0;
         end else if (flush) begin
            valid_q <= 1'b0;
         end else if (we) begin
            valid_q <= 1'b1;
            mod_q   <= fill_mod;
            vpn_q   <= fill_vpn;
            pfn_q   <= fill_pfn;
         end else if (mark) begin
            mod_q   <= 1'b1;
         end
      end

      assign ent_valid[g] = valid_q;
      assign ent_mod[g]   = mod_q;
      assign ent_vpn[g]   = vpn_q;
      assign ent_pfn[g]   = pfn_q;
      assign match[g]     = valid_q && (vpn_q == lookup_vpn);
   end

   always_comb begin
      hit     = 1'b0;
      hit_idx = '0;
      hit_pfn = '0;
      hit_mod = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (match[i]) begin
            hit     = 1'b1;
            hit_idx = IDX_W'(i);
            hit_pfn = hit_pfn | ent_pfn[i];
            hit_mod = hit_mod | ent_mod[i];
         end
      end
   end

   always_comb begin
      any_free = 1'b0;
      free_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!ent_valid[i]) begin
            any_free = 1'b1;
            free_idx = IDX_W'(i);
         end
      end
   end

   assign victim = any_free ? free_idx : rr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rr_q <= '0;
      end else if (do_fill && !any_free) begin
         rr_q <= (rr_q == LAST_IDX) ? '0 : rr_q + 1'b1;
      end
   end

endmodule

// File: rtl/xlat_page_table.sv
module xlat_page_table #(
   parameter int VPN_W = 8,
   parameter int PFN_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inst_en,
   input  logic [VPN_W-1:0] inst_vpn,
   input  logic             inst_present,
   input  logic             inst_mod,
   input  logic [PFN_W-1:0] inst_pfn,
   input  logic             mark_en,
   input  logic [VPN_W-1:0] mark_vpn,
   input  logic             rd_en,
   input  logic [VPN_W-1:0] rd_vpn,
   output logic             rd_present,
   output logic             rd_mod,
   output logic [PFN_W-1:0] rd_pfn
);

   localparam int DEPTH = 1 << VPN_W;

   if (VPN_W > 12) begin : g_bad_depth
      $error("xlat_page_table: VPN_W above 12 makes the table too large");
   end

   logic [DEPTH-1:0] pres_mem;
   logic [DEPTH-1:0] mod_mem;
   logic [PFN_W-1:0] pfn_mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pres_mem <= '0;
         mod_mem  <= '0;
      end else begin
         if (mark_en) begin
            mod_mem[mark_vpn] <= 1'b1;
         end
         if (inst_en) begin
            pres_mem[inst_vpn] <= inst_present;
            mod_mem[inst_vpn]  <= inst_mod;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (inst_en) begin
         pfn_mem[inst_vpn] <= inst_pfn;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_present <= 1'b0;
         rd_mod     <= 1'b0;
         rd_pfn     <= '0;
      end else if (rd_en) begin
         rd_present <= pres_mem[rd_vpn];
         rd_mod     <= mod_mem[rd_vpn];
         rd_pfn     <= pfn_mem[rd_vpn];
      end
   end

endmodule

// File: rtl/xlat_walk_ctrl.sv
module xlat_walk_ctrl
   import xlat_pkg::*;
#(
   parameter int VPN_W    = 8,
   parameter int PFN_W    = 6,
   parameter int OFFSET_W = 8,
   parameter int IDX_W    = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   input  logic                      req_write,
   input  logic [VPN_W-1:0]          req_vpn,
   input  logic [OFFSET_W-1:0]       req_off,
   output logic                      req_ready,
   input  logic                      cam_hit,
   input  logic [IDX_W-1:0]          cam_hit_idx,
   input  logic [PFN_W-1:0]          cam_hit_pfn,
   input  logic                      cam_hit_mod,
   output logic                      fill_en,
   output logic [VPN_W-1:0]          fill_vpn,
   output logic [PFN_W-1:0]          fill_pfn,
   output logic                      fill_mod,
   output logic                      setmod_en,
   output logic [IDX_W-1:0]          setmod_idx,
   output logic                      pt_rd_en,
   output logic [VPN_W-1:0]          pt_rd_vpn,
   input  logic                      pt_present,
   input  logic                      pt_mod,
   input  logic [PFN_W-1:0]          pt_pfn,
   output logic                      mark_en,
   output logic [VPN_W-1:0]          mark_vpn,
   output logic                      rsp_valid,
   output logic [PFN_W+OFFSET_W-1:0] rsp_paddr,
   output logic                      rsp_fault,
   output logic                      rsp_modified
);

   walk_state_e           state_q;
   logic [VPN_W-1:0]      lat_vpn;
   logic [OFFSET_W-1:0]   lat_off;
   logic                  lat_wr;

   logic accept;
   logic hit_acc;
   logic miss_acc;
   logic in_check;
   logic walk_ok;

   assign req_ready = (state_q == WALK_IDLE);
   assign accept    = req_valid && req_ready;
   assign hit_acc   = accept && cam_hit;
   assign miss_acc  = accept && !cam_hit;
   assign in_check  = (state_q == WALK_CHECK);
   assign walk_ok   = in_check && pt_present;

   assign setmod_en  = hit_acc && req_write && !cam_hit_mod;
   assign setmod_idx = cam_hit_idx;

   assign fill_en  = walk_ok;
   assign fill_vpn = lat_vpn;
   assign fill_pfn = pt_pfn;
   assign fill_mod = pt_mod | lat_wr;

   assign mark_en  = setmod_en || (walk_ok && lat_wr && !pt_mod);
   assign mark_vpn = in_check ? lat_vpn : req_vpn;

   assign pt_rd_en  = (state_q == WALK_FETCH);
   assign pt_rd_vpn = lat_vpn;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WALK_IDLE;
         lat_vpn <= '0;
         lat_off <= '0;
         lat_wr  <= 1'b0;
      end else begin
         case (state_q)
            WALK_IDLE: begin
               if (miss_acc) begin
                  state_q <= WALK_FETCH;
                  lat_vpn <= req_vpn;
                  lat_off <= req_off;
                  lat_wr  <= req_write;
               end
            end
            WALK_FETCH: state_q <= WALK_CHECK;
            default:    state_q <= WALK_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_paddr    <= '0;
         rsp_fault    <= 1'b0;
         rsp_modified <= 1'b0;
      end else begin
         rsp_valid <= hit_acc || in_check;
         if (hit_acc) begin
            rsp_paddr    <= {cam_hit_pfn, req_off};
            rsp_fault    <= 1'b0;
            rsp_modified <= cam_hit_mod | req_write;
         end else if (walk_ok) begin
            rsp_paddr    <= {pt_pfn, lat_off};
            rsp_fault    <= 1'b0;
            rsp_modified <= pt_mod | lat_wr;
         end else if (in_check) begin
            rsp_paddr    <= '0;
            rsp_fault    <= 1'b1;
            rsp_modified <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
   parameter int VADDR_W  = 16,
   parameter int OFFSET_W = 8,
   parameter int PADDR_W  = 14,
   parameter int ENTRIES  = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          flush,
   input  logic                          req_valid,
   output logic                          req_ready,
   input  logic [VADDR_W-1:0]            req_vaddr,
   input  logic                          req_write,
   output logic                          rsp_valid,
   output logic [PADDR_W-1:0]            rsp_paddr,
   output logic                          rsp_fault,
   output logic                          rsp_modified,
   input  logic                          pte_wr_en,
   input  logic [VADDR_W-OFFSET_W-1:0]   pte_wr_vpn,
   input  logic                          pte_wr_present,
   input  logic                          pte_wr_modified,
   input  logic [PADDR_W-OFFSET_W-1:0]   pte_wr_frame
);

   localparam int VPN_W = VADDR_W - OFFSET_W;
   localparam int PFN_W = PADDR_W - OFFSET_W;
   localparam int IDX_W = xlat_pkg::idx_bits(ENTRIES);

   if (OFFSET_W < 1 || VPN_W < 1 || PFN_W < 1) begin : g_bad_widths
      $error("xlat_tlb: address widths must leave room for page and frame numbers");
   end

   logic [VPN_W-1:0]    req_vpn;
   logic [OFFSET_W-1:0] req_off;

   logic             cam_hit;
   logic [IDX_W-1:0] cam_hit_idx;
   logic [PFN_W-1:0] cam_hit_pfn;
   logic             cam_hit_mod;
   logic             fill_en;
   logic [VPN_W-1:0] fill_vpn;
   logic [PFN_W-1:0] fill_pfn;
   logic             fill_mod;
   logic             setmod_en;
   logic [IDX_W-1:0] setmod_idx;
   logic             pt_rd_en;
   logic [VPN_W-1:0] pt_rd_vpn;
   logic             pt_present;
   logic             pt_mod;
   logic [PFN_W-1:0] pt_pfn;
   logic             mark_en;
   logic [VPN_W-1:0] mark_vpn;

   assign req_vpn = req_vaddr[VADDR_W-1:OFFSET_W];
   assign req_off = req_vaddr[OFFSET_W-1:0];

   xlat_tlb_cam #(
      .ENTRIES (ENTRIES),
      .VPN_W   (VPN_W),
      .PFN_W   (PFN_W),
      .IDX_W   (IDX_W)
   ) u_cam (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .lookup_vpn (req_vpn),
      .hit        (cam_hit),
      .hit_idx    (cam_hit_idx),
      .hit_pfn    (cam_hit_pfn),
      .hit_mod    (cam_hit_mod),
      .fill_en    (fill_en),
      .fill_vpn   (fill_vpn),
      .fill_pfn   (fill_pfn),
      .fill_mod   (fill_mod),
      .setmod_en  (setmod_en),
      .setmod_idx (setmod_idx)
   );

   xlat_page_table #(
      .VPN_W (VPN_W),
      .PFN_W (PFN_W)
   ) u_pt (
      .clk          (clk),
      .rst_n        (rst_n),
      .inst_en      (pte_wr_en),
      .inst_vpn     (pte_wr_vpn),
      .inst_present (pte_wr_present),
      .inst_mod     (pte_wr_modified),
      .inst_pfn     (pte_wr_frame),
      .mark_en      (mark_en),
      .mark_vpn     (mark_vpn),
      .rd_en        (pt_rd_en),
      .rd_vpn       (pt_rd_vpn),
      .rd_present   (pt_present),
      .rd_mod       (pt_mod),
      .rd_pfn       (pt_pfn)
   );

   xlat_walk_ctrl #(
      .VPN_W    (VPN_W),
      .PFN_W    (PFN_W),
      .OFFSET_W (OFFSET_W),
      .IDX_W    (IDX_W)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_write    (req_write),
      .req_vpn      (req_vpn),
      .req_off      (req_off),
      .req_ready    (req_ready),
      .cam_hit      (cam_hit),
      .cam_hit_idx  (cam_hit_idx),
      .cam_hit_pfn  (cam_hit_pfn),
      .cam_hit_mod  (cam_hit_mod),
      .fill_en      (fill_en),
      .fill_vpn     (fill_vpn),
      .fill_pfn     (fill_pfn),
      .fill_mod     (fill_mod),
      .setmod_en    (setmod_en),
      .setmod_idx   (setmod_idx),
      .pt_rd_en     (pt_rd_en),
      .pt_rd_vpn    (pt_rd_vpn),
      .pt_present   (pt_present),
      .pt_mod       (pt_mod),
      .pt_pfn       (pt_pfn),
      .mark_en      (mark_en),
      .mark_vpn     (mark_vpn),
      .rsp_valid    (rsp_valid),
      .rsp_paddr    (rsp_paddr),
      .rsp_fault    (rsp_fault),
      .rsp_modified (rsp_modified)
   );

endmodule

// File: rtl/xlat_tlb_chk.sv
module xlat_tlb_chk #(
   parameter int PADDR_W = 14
) (
   input logic               clk,
   input logic               rst_n,
   input logic               flush,
   input logic               req_valid,
   input logic               req_ready,
   input logic               req_write,
   input logic               rsp_valid,
   input logic [PADDR_W-1:0] rsp_paddr,
   input logic               rsp_fault,
   input logic               rsp_modified,
   input logic               cam_hit
);

   logic acc_hit;
   logic acc_miss;

   assign acc_hit  = req_valid && req_ready && cam_hit;
   assign acc_miss = req_valid && req_ready && !cam_hit;

   AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      acc_hit |=> (rsp_valid && !rsp_fault)); // R1

   AST_MISS_THIRD_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(acc_miss, 2) |=> rsp_valid); // R2

   AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && !rsp_modified)); // R3

   AST_WRITE_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_hit && req_write) |=> rsp_modified); // R5

   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !cam_hit); // R7

   AST_BUSY_AFTER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      acc_miss |=> !req_ready); // R8

endmodule

bind xlat_tlb xlat_tlb_chk #(.PADDR_W(PADDR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .flush        (flush),
   .req_valid    (req_valid),
   .req_ready    (req_ready),
   .req_write    (req_write),
   .rsp_valid    (rsp_valid),
   .rsp_paddr    (rsp_paddr),
   .rsp_fault    (rsp_fault),
   .rsp_modified (rsp_modified),
   .cam_hit      (cam_hit)
);

// File: tb/xlat_tlb_tb.sv
module xlat_tlb_tb;

   localparam int VA_W  = 16;
   localparam int OFF_W = 8;
   localparam int PA_W  = 14;
   localparam int NENT  = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             flush = 1'b0;
   logic             req_valid = 1'b0;
   logic             req_ready;
   logic [VA_W-1:0]  req_vaddr = '0;
   logic             req_write = 1'b0;
   logic             rsp_valid;
   logic [PA_W-1:0]  rsp_paddr;
   logic             rsp_fault;
   logic             rsp_modified;
   logic             pte_wr_en = 1'b0;
   logic [7:0]       pte_wr_vpn = '0;
   logic             pte_wr_present = 1'b0;
   logic             pte_wr_modified = 1'b0;
   logic [5:0]       pte_wr_frame = '0;

   always #5 clk = ~clk;

   xlat_tlb #(.VADDR_W(VA_W), .OFFSET_W(OFF_W), .PADDR_W(PA_W), .ENTRIES(NENT)) u_dut (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
      .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_modified(rsp_modified),
      .pte_wr_en(pte_wr_en), .pte_wr_vpn(pte_wr_vpn), .pte_wr_present(pte_wr_present),
      .pte_wr_modified(pte_wr_modified), .pte_wr_frame(pte_wr_frame)
   );

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit live = 0;
   bit done = 0;

   typedef struct {
      int    due;
      int    pa;
      bit    flt;
      bit    md;
      string tag;
   } exp_t;
   exp_t expq[$];

   // behavioural reference state
   bit m_v[NENT];
   int m_vpn[NENT];
   int m_pfn[NENT];
   bit m_m[NENT];
   int m_rr = 0;
   bit pt_p[256];
   bit pt_m[256];
   int pt_f[256];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input string what, input int act, input int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
      end
   endtask

   always @(negedge clk) begin
      if (live) begin
         if (expq.size() > 0 && expq[0].due == cyc) begin
            exp_t e;
            e = expq.pop_front();
            check(rsp_valid == 1'b1, e.tag, "rsp_valid", int'(rsp_valid), 1);
            check({rsp_fault, rsp_modified, rsp_paddr} == {e.flt, e.md, PA_W'(e.pa)}, e.tag,
                  "fault/modified/paddr", int'({rsp_fault, rsp_modified, rsp_paddr}),
                  int'({e.flt, e.md, PA_W'(e.pa)}));
         end else if (rsp_valid) begin
            check(1'b0, "R2", "unexpected rsp_valid", 1, 0);
         end
      end
   end

   task automatic install(input int vpn, input bit p, input bit md, input int frame);
      @(negedge clk);
      pte_wr_en = 1'b1;
      pte_wr_vpn = 8'(vpn);
      pte_wr_present = p;
      pte_wr_modified = md;
      pte_wr_frame = 6'(frame);
      pt_p[vpn] = p;
      pt_m[vpn] = md;
      pt_f[vpn] = frame;
      @(negedge clk);
      pte_wr_en = 1'b0;
   endtask

   task automatic do_flush();
      @(negedge clk);
      flush = 1'b1;
      for (int i = 0; i < NENT; i++) m_v[i] = 1'b0;
      @(negedge clk);
      flush = 1'b0;
   endtask

   // one translation; stray drives a second request while the walk is busy
   task automatic xlate(input int vpn, input int off, input bit wr, input string tag, input bit stray);
      int  hi;
      bit  hit;
      exp_t e;
      @(negedge clk);
      check(req_ready == 1'b1, "R8", "req_ready before request", int'(req_ready), 1);
      hi = -1;
      for (int i = 0; i < NENT; i++) if (m_v[i] && m_vpn[i] == vpn) hi = i;
      hit = (hi >= 0);
      e.tag = tag;
      if (hit) begin
         e.due = cyc + 1;
         e.flt = 1'b0;
         e.pa  = (m_pfn[hi] << OFF_W) | off;
         if (wr && !m_m[hi]) begin
            m_m[hi] = 1'b1;
            pt_m[vpn] = 1'b1;
         end
         e.md = m_m[hi];
      end else begin
         e.due = cyc + 3;
         if (!pt_p[vpn]) begin
            e.flt = 1'b1;
            e.pa  = 0;
            e.md  = 1'b0;
         end else begin
            int vic;
            vic = -1;
            for (int i = NENT - 1; i >= 0; i--) if (!m_v[i]) vic = i;
            if (vic < 0) begin
               vic = m_rr;
               m_rr = (m_rr + 1) % NENT;
            end
            if (wr) pt_m[vpn] = 1'b1;
            m_v[vic] = 1'b1;
            m_vpn[vic] = vpn;
            m_pfn[vic] = pt_f[vpn];
            m_m[vic] = pt_m[vpn];
            e.flt = 1'b0;
            e.pa  = (pt_f[vpn] << OFF_W) | off;
            e.md  = pt_m[vpn];
         end
      end
      expq.push_back(e);
      req_valid = 1'b1;
      req_vaddr = VA_W'((vpn << OFF_W) | off);
      req_write = wr;
      @(negedge clk);
      if (hit) begin
         req_valid = 1'b0;
      end else begin
         check(req_ready == 1'b0, "R8", "req_ready during walk", int'(req_ready), 0);
         if (stray) begin
            req_vaddr = VA_W'(((vpn ^ 1) << OFF_W) | 8'h5A);
            req_write = 1'b1;
            @(negedge clk);
            @(negedge clk);
            req_valid = 1'b0;
         end else begin
            req_valid = 1'b0;
            @(negedge clk);
         end
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int s;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      live = 1'b1;
      @(negedge clk);
      // R9 reset state
      check(req_ready == 1'b1, "R9", "req_ready after reset", int'(req_ready), 1);
      check(rsp_valid == 1'b0, "R9", "rsp_valid after reset", int'(rsp_valid), 0);

      for (int v = 0; v < 16; v++) install(v, (v != 5 && v != 9), 1'b0, (v * 7 + 3) & 63);

      xlate(1, 8'h34, 0, "R2", 0);  // miss, fill slot 0
      xlate(1, 8'hC1, 0, "R10", 0); // repeat hits
      xlate(1, 8'h02, 0, "R1", 0);
      xlate(1, 8'h10, 1, "R5", 0);  // first write hit sets dirty
      xlate(1, 8'h11, 0, "R6", 0);
      xlate(2, 8'hFF, 0, "R6", 0);  // clean page read
      xlate(2, 8'h00, 0, "R6", 0);
      xlate(5, 8'h44, 0, "R3", 0);  // not present
      xlate(5, 8'h45, 1, "R3", 0);  // still misses
      xlate(3, 8'h01, 0, "R4", 0);
      xlate(4, 8'h02, 0, "R4", 0);  // cache full
      xlate(6, 8'h03, 0, "R4", 0);  // rotating victim
      xlate(7, 8'h04, 0, "R4", 0);
      xlate(1, 8'h05, 0, "R4", 0);
      xlate(4, 8'h06, 0, "R1", 0);
      xlate(3, 8'h07, 0, "R4", 0);

      do_flush();
      xlate(4, 8'h08, 0, "R7", 0);  // misses after flush
      xlate(1, 8'h09, 0, "R5", 0);  // table dirty bit seen on refill
      xlate(2, 8'h0A, 0, "R6", 0);
      xlate(8, 8'h0B, 1, "R5", 0);  // write miss
      do_flush();
      xlate(8, 8'h0C, 0, "R5", 0);
      xlate(10, 8'h0D, 0, "R8", 1); // stray request ignored
      xlate(11, 8'h0E, 0, "R8", 0);
      xlate(10, 8'h0F, 0, "R8", 0);

      s = 12345;
      for (int k = 0; k < 60; k++) begin
         s = (s * 1103515245 + 12345) & 32'h7fffffff;
         xlate((s >> 8) % 12, (s >> 16) & 255, s[3], "R4", 0);
      end
      do_flush();
      xlate(9, 8'h20, 0, "R3", 0);

      repeat (6) @(negedge clk);
      check(expq.size() == 0, "R2", "responses outstanding", expq.size(), 0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule